// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Per-Pin Edge Interrupts

This block is a bank of general-purpose pins behind a simple synchronous register bus. Each pin has a direction bit and an output-data bit. Software changes output bits either by writing the whole output word or, without a read-modify-write, by writing ones to a set register or to a clear register. Input levels pass through a two-flop synchronizer before any logic uses them. The synchronized level can be read back at any time.

Each pin can be armed for rising edges, falling edges or both. The rising and falling enable masks are each changed only through their own set and clear registers. A detected, armed edge gives a one-cycle pulse on that pin's event line. The same pulse appears on that pin's interrupt line only while the bank interrupt gate is on. There is no combined bank interrupt. Downstream interrupt or DMA logic takes the per-pin lines directly.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction bit is 1 (input), every output-data bit is 0, both trigger masks and the bank gate are 0, and every irq and event line is low.
- R2: Offset 0x10 is the direction register. It is read/write, a bit of 1 means input, and pin_dir_o follows it.
- R3: Offset 0x14 holds the output data and can be written directly. A one written at 0x18 sets that output bit and a one written at 0x1C clears it, while zero bits leave it unchanged. Reads of 0x14, 0x18 and 0x1C all return the output data, which drives pin_out_o.
- R4: A one written at 0x24 arms that pin for rising edges and a one at 0x28 disarms it. A one at 0x2C arms falling edges and a one at 0x30 disarms them. Reads of 0x24 and 0x28 return the rising mask, and reads of 0x2C and 0x30 return the falling mask.
- R5: Offset 0x20 returns the synchronized pin level whatever the direction. A change on pin_in_i is visible there after the second rising clock edge.
- R6: A change on an armed pin at the pin's input raises evt_o for that pin for exactly one cycle, after the third rising clock edge. irq_o pulses in the same cycle only when bit 0 of the bank gate is 1. Edges of a kind the pin is not armed for produce no pulse.
- R7: A pin armed for both kinds pulses on each rising edge and on each falling edge.
- R8: Offset 0x08 is the bank gate. Only bit 0 is stored, and a read returns that bit with all upper bits 0.
- R9: Reads of 0x0C and of any unmapped offset up to 0x3FF return 0. Writes to them change no register.
- R10: An edge is judged against the masks as they stood before the clock edge that evaluates it. A mask write landing on that same clock edge affects only later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_in_i | input | 32 | Asynchronous pin levels |
| pin_out_o | output | 32 | Output data to the pad drivers |
| pin_dir_o | output | 32 | Direction per pin, 1 = input |
| evt_o | output | 32 | Per-pin edge event pulse |
| irq_o | output | 32 | Per-pin interrupt pulse, gated by the bank enable |

## Verification
Register writes and edge evaluation can fall on the same clock edge. The sharpest case is a mask-clear write that lands exactly on the edge where a synchronized pin change is judged. The bench times a pin change so that its evaluating edge coincides with a write to the rising-disarm register. It expects that edge to still pulse and the mask to read back cleared afterwards. Bank-gate toggling against live edges is judged the same way: the event line must fire while the interrupt line stays quiet.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 10;

  localparam logic [ADDR_W-1:0] OFS_BANK_EN  = 10'h008;
  localparam logic [ADDR_W-1:0] OFS_DIR      = 10'h010;
  localparam logic [ADDR_W-1:0] OFS_OUT      = 10'h014;
  localparam logic [ADDR_W-1:0] OFS_OUT_SET  = 10'h018;
  localparam logic [ADDR_W-1:0] OFS_OUT_CLR  = 10'h01C;
  localparam logic [ADDR_W-1:0] OFS_IN       = 10'h020;
  localparam logic [ADDR_W-1:0] OFS_RISE_SET = 10'h024;
  localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 10'h028;
  localparam logic [ADDR_W-1:0] OFS_FALL_SET = 10'h02C;
  localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 10'h030;
  localparam logic [ADDR_W-1:0] OFS_RSVD     = 10'h00C;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[k] <= '0;
      else         stage_q[k] <= stage_q[k-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] rise_en_i,
  input  logic [WIDTH-1:0] fall_en_i,
  input  logic             bank_en_i,
  output logic [WIDTH-1:0] evt_o,
  output logic [WIDTH-1:0] irq_o
);
  logic [WIDTH-1:0] prev_q, evt_q, irq_q, hit;

  always_comb begin
    hit = (sync_i & ~prev_q & rise_en_i) | (~sync_i & prev_q & fall_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      evt_q  <= '0;
      irq_q  <= '0;
    end else begin
      prev_q <= sync_i;
      evt_q  <= hit;
      irq_q  <= hit & {WIDTH{bank_en_i}};
    end
  end

  assign evt_o = evt_q;
  assign irq_o = irq_q;

  // R6: an event needs a level change on that pin in the previous cycle
  assert_evt_needs_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_q & ~$past(sync_i ^ prev_q)) == '0));
  // R6: interrupts only while the bank gate was on
  assert_irq_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_q) |-> $past(bank_en_i));
  // R6: pulses last one cycle
  assert_one_cycle_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_q & $past(evt_q)) == '0));
  // R10: edge judged against masks from before the evaluating edge
  assert_mask_before_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_q & ~($past(rise_en_i) | $past(fall_en_i))) == '0));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  in_sync_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  out_o,
  output logic [WIDTH-1:0]  rise_en_o,
  output logic [WIDTH-1:0]  fall_en_o,
  output logic              bank_en_o
);
  logic [WIDTH-1:0] dir_q, out_q, rise_q, fall_q;
  logic             bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      bank_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        OFS_BANK_EN:  bank_q <= wdata_i[0];
        OFS_DIR:      dir_q  <= wdata_i;
        OFS_OUT:      out_q  <= wdata_i;
        OFS_OUT_SET:  out_q  <= out_q | wdata_i;
        OFS_OUT_CLR:  out_q  <= out_q & ~wdata_i;
        OFS_RISE_SET: rise_q <= rise_q | wdata_i;
        OFS_RISE_CLR: rise_q <= rise_q & ~wdata_i;
        OFS_FALL_SET: fall_q <= fall_q | wdata_i;
        OFS_FALL_CLR: fall_q <= fall_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_BANK_EN:                       rdata_o = {{(WIDTH-1){1'b0}}, bank_q};
      OFS_DIR:                           rdata_o = dir_q;
      OFS_OUT, OFS_OUT_SET, OFS_OUT_CLR: rdata_o = out_q;
      OFS_IN:                            rdata_o = in_sync_i;
      OFS_RISE_SET, OFS_RISE_CLR:        rdata_o = rise_q;
      OFS_FALL_SET, OFS_FALL_CLR:        rdata_o = fall_q;
      default:                           rdata_o = '0;
    endcase
  end

  assign dir_o     = dir_q;
  assign out_o     = out_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign bank_en_o = bank_q;

  assert_set_forces_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_OUT_SET) |=> ((out_q & $past(wdata_i)) == $past(wdata_i)));
  assert_clr_forces_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_OUT_CLR) |=> ((out_q & $past(wdata_i)) == '0));
  assert_rsvd_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_RSVD) |=> ($stable(out_q) && $stable(dir_q) && $stable(rise_q)
                                        && $stable(fall_q) && $stable(bank_q)));
  assert_bank_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_BANK_EN) |-> (rdata_o[WIDTH-1:1] == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_dir_o,
  output logic [NUM_PINS-1:0] evt_o,
  output logic [NUM_PINS-1:0] irq_o
);
  logic [NUM_PINS-1:0] in_sync, rise_en, fall_en;
  logic                bank_en;

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(pin_in_i), .sync_o(in_sync)
  );

  gpio_regfile #(.WIDTH(NUM_PINS)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .in_sync_i(in_sync), .rdata_o, .dir_o(pin_dir_o), .out_o(pin_out_o),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .bank_en_o(bank_en)
  );

  gpio_edge_det #(.WIDTH(NUM_PINS)) u_edge (
    .clk_i, .rst_ni, .sync_i(in_sync), .rise_en_i(rise_en), .fall_en_i(fall_en),
    .bank_en_i(bank_en), .evt_o, .irq_o
  );

  assert_irq_within_evt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~evt_o) == '0));
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  typedef struct {
    int          kind;  // 0 rdata, 1 irq, 2 evt, 3 pin_out, 4 pin_dir
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [9:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata, pin_in = '0, pin_out, pin_dir, evt, irq;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  item_t sb_q[$];
  event  sample_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_dir_o(pin_dir),
    .evt_o(evt), .irq_o(irq)
  );

  // monitor: pops expected items and compares against the design outputs
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = rdata;
          1: act = irq;
          2: act = evt;
          3: act = pin_out;
          default: act = pin_dir;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    -> sample_ev;
    #1;
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(logic [9:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1;
    expect_val(0, exp, tag);
  endtask

  // change pins, then check the pulse after the third edge and its end after the fourth
  task automatic pin_edge(logic [31:0] lvl, logic [31:0] exp_evt, logic [31:0] exp_irq, string tag);
    @(negedge clk);
    pin_in = lvl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_val(2, exp_evt, tag);
    expect_val(1, exp_irq, tag);
    @(negedge clk);
    expect_val(2, 32'h0, {tag, " end"});
    expect_val(1, 32'h0, {tag, " end"});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_val(4, 32'hFFFF_FFFF, "R1 pin_dir");
    expect_val(3, 32'h0, "R1 pin_out");
    expect_val(1, 32'h0, "R1 irq");
    expect_val(2, 32'h0, "R1 evt");
    chk_rd(10'h010, 32'hFFFF_FFFF, "R1 dir read");
    chk_rd(10'h024, 32'h0, "R1 rise mask");
    chk_rd(10'h02C, 32'h0, "R1 fall mask");
    chk_rd(10'h008, 32'h0, "R1 bank gate");

    // R2 direction
    wr(10'h010, 32'h0000_FFFF);
    chk_rd(10'h010, 32'h0000_FFFF, "R2 dir read");
    expect_val(4, 32'h0000_FFFF, "R2 pin_dir");

    // R3 output data, set and clear
    wr(10'h014, 32'hA5A5_0000);
    chk_rd(10'h014, 32'hA5A5_0000, "R3 direct write");
    wr(10'h018, 32'h0000_000F);
    chk_rd(10'h014, 32'hA5A5_000F, "R3 set");
    wr(10'h01C, 32'hA000_0001);
    chk_rd(10'h018, 32'h05A5_000E, "R3 clear via set read");
    chk_rd(10'h01C, 32'h05A5_000E, "R3 clear read");
    expect_val(3, 32'h05A5_000E, "R3 pin_out");

    // R5 synchronized input, masks still zero
    @(negedge clk);
    pin_in = 32'h1234_5678;
    @(posedge clk);
    @(negedge clk);
    addr = 10'h020;
    #1;
    expect_val(0, 32'h0, "R5 not yet after one edge");
    @(posedge clk);
    @(negedge clk);
    #1;
    expect_val(0, 32'h1234_5678, "R5 input after two edges");
    expect_val(2, 32'h0, "R6 unarmed no event");
    @(negedge clk);
    pin_in = 32'h0;
    repeat (4) @(posedge clk);

    // R4 trigger masks
    wr(10'h024, 32'h0000_01FF);
    wr(10'h028, 32'h0000_000F);
    chk_rd(10'h024, 32'h0000_01F0, "R4 rise set/clear");
    chk_rd(10'h028, 32'h0000_01F0, "R4 rise clr read");
    wr(10'h02C, 32'h0000_0F00);
    chk_rd(10'h030, 32'h0000_0F00, "R4 fall read");

    // R8 bank gate holds bit 0 only
    wr(10'h008, 32'hFFFF_FFFF);
    chk_rd(10'h008, 32'h0000_0001, "R8 bank read");

    // R6 rising edges on two pins
    pin_edge(32'h0000_0030, 32'h0000_0030, 32'h0000_0030, "R6 rise two pins");
    // R7 bit 8 armed both ways
    pin_edge(32'h0000_0130, 32'h0000_0100, 32'h0000_0100, "R7 rise");
    pin_edge(32'h0000_0030, 32'h0000_0100, 32'h0000_0100, "R7 fall");
    // R6 bit 9 armed only for falling: rise ignored
    pin_edge(32'h0000_0230, 32'h0000_0000, 32'h0000_0000, "R6 unarmed kind");
    // R6 gate off: event without irq
    wr(10'h008, 32'h0);
    pin_edge(32'h0000_02B0, 32'h0000_0080, 32'h0000_0000, "R6 gate off");
    wr(10'h008, 32'h1);

    // R10 disarm write on the evaluating edge
    @(negedge clk);
    pin_in = 32'h0000_02F0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    addr = 10'h028; wdata = 32'h0000_0040; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    expect_val(2, 32'h0000_0040, "R10 evt same-edge clear");
    expect_val(1, 32'h0000_0040, "R10 irq same-edge clear");
    chk_rd(10'h024, 32'h0000_01B0, "R10 mask cleared after");
    pin_edge(32'h0000_02B0, 32'h0000_0000, 32'h0000_0000, "R10 later edge");
    pin_edge(32'h0000_02F0, 32'h0000_0000, 32'h0000_0000, "R10 disarmed rise");

    // R9 reserved and unmapped
    wr(10'h00C, 32'hFFFF_FFFF);
    chk_rd(10'h00C, 32'h0, "R9 reserved read");
    wr(10'h100, 32'hFFFF_FFFF);
    chk_rd(10'h100, 32'h0, "R9 unmapped read");
    chk_rd(10'h014, 32'h05A5_000E, "R9 out untouched");
    chk_rd(10'h010, 32'h0000_FFFF, "R9 dir untouched");
    chk_rd(10'h024, 32'h0000_01B0, "R9 rise untouched");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule